// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural registers of a processor core that runs in one of several operating modes. Software addresses sixteen logical registers with a 4-bit index. For some indices the physical location depends on the mode the core is in. The fast-interrupt mode has a private copy of registers 8 to 14. The interrupt, supervisor, abort and undefined modes each keep a private pair for registers 13 and 14. User and system modes work on one common set. Every physical location is a flop word, 37 words in total.

Alongside the general registers the file holds one current status word, which is common to all modes. Each of the five exception modes also has a saved status word of its own. The mode input steers all ports at once: both read ports, the write port and the saved status port. The core's decoder drives the two read indices and the write index each cycle. Exception sequencing uses the status ports.

Reads are combinational from the stored contents. Writes land on the rising clock edge, so a write shows up on a read of the same location in the following cycle.

Top module: `banked_regfile`

## Requirements
- R1: After reset every general register in every mode, the current status word and every saved status word read as zero.
- R2: Mode codes are 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. User (0x10) and system (0x1F) address the same sixteen registers.
- R3: In mode 0x11, indices 8 through 14 select seven private locations. A write there does not change what user mode reads at those indices, and a user write does not change what fast-interrupt mode reads there.
- R4: Modes 0x12, 0x13, 0x17 and 0x1B each own private locations for indices 13 and 14, distinct from each other and from user and fast-interrupt mode. Their indices 8 to 12 are the user-mode registers.
- R5: Indices 0 to 7 and index 15 select the same location in every mode.
- R6: Each of the five exception modes has its own saved status word, written through the saved-status write port and read on the saved-status output while that mode is selected.
- R7: In user or system mode the saved-status output reads zero, and a saved-status write changes no stored word.
- R8: Any mode value other than the seven listed maps the general registers as user mode, and it behaves like R7 for saved status.
- R9: The current status word is a single location, written and read identically in every mode.
- R10: A write lands on the rising edge. A read of that location in the same cycle returns the previous contents, and a read in the next cycle returns the new value.
- R11: The two read ports select and return their locations independently, in any mixture of modes, indices and concurrent writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current operating mode code |
| rd_a_idx_i | input | 4 | Logical index for read port A |
| rd_a_data_o | output | DATA_W | Read port A data |
| rd_b_idx_i | input | 4 | Logical index for read port B |
| rd_b_data_o | output | DATA_W | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | Logical index for the write |
| wr_data_i | input | DATA_W | General register write data |
| stat_wr_en_i | input | 1 | Current status write enable |
| stat_wr_data_i | input | DATA_W | Current status write data |
| stat_rd_o | output | DATA_W | Current status word |
| save_wr_en_i | input | 1 | Saved status write enable for the current mode |
| save_wr_data_i | input | DATA_W | Saved status write data |
| save_rd_o | output | DATA_W | Saved status word of the current mode, zero when it has none |

## Verification
A unique value is written into each location. Reading it back in other modes then separates shared indices from banked ones. A fast-interrupt value showing up in user mode, or one exception pair leaking into another, shows as a wrong number. Saved-status writes in user, system and undefined codes are followed by reads in every exception mode, which shows that they were dropped. A same-cycle write-and-read pair tells the old value from the new one. A long pseudo-random mix of modes (unlisted codes included), indices and concurrent writes on every port is compared with a per-bank bench model, which catches remapping errors that only appear in combination.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int MODE_W  = 5;
  localparam int IDX_W   = 4;
  localparam int NUM_LOG = 1 << IDX_W;

  localparam logic [MODE_W-1:0] MD_USR = 5'h10;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MD_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MD_SYS = 5'h1F;

  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND
  } bank_e;

  // banked index windows
  localparam int FIQ_LO   = 8;
  localparam int FIQ_HI   = 14;
  localparam int FIQ_CNT  = FIQ_HI - FIQ_LO + 1;
  localparam int PAIR_LO  = 13;
  localparam int PAIR_CNT = 2;

  // physical layout: shared words, status word, then one group per
  // exception mode holding its banked words followed by its saved status
  localparam int SLOT_STAT = NUM_LOG;
  localparam int SLOT_FIQ  = SLOT_STAT + 1;
  localparam int SLOT_SVC  = SLOT_FIQ + FIQ_CNT + 1;
  localparam int SLOT_ABT  = SLOT_SVC + PAIR_CNT + 1;
  localparam int SLOT_IRQ  = SLOT_ABT + PAIR_CNT + 1;
  localparam int SLOT_UND  = SLOT_IRQ + PAIR_CNT + 1;
  localparam int DEPTH     = SLOT_UND + PAIR_CNT + 1;
  localparam int PHYS_W    = $clog2(DEPTH);

  function automatic int group_base(bank_e b);
    case (b)
      BK_FIQ:  return SLOT_FIQ;
      BK_SVC:  return SLOT_SVC;
      BK_ABT:  return SLOT_ABT;
      BK_IRQ:  return SLOT_IRQ;
      BK_UND:  return SLOT_UND;
      default: return 0;
    endcase
  endfunction

  function automatic int group_size(bank_e b);
    case (b)
      BK_FIQ:  return FIQ_CNT;
      BK_USR:  return 0;
      default: return PAIR_CNT;
    endcase
  endfunction

endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
  import bankreg_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank,
  output logic              priv
);

  always_comb begin
    case (mode)
      MD_FIQ:  bank = BK_FIQ;
      MD_IRQ:  bank = BK_IRQ;
      MD_SVC:  bank = BK_SVC;
      MD_ABT:  bank = BK_ABT;
      MD_UND:  bank = BK_UND;
      default: bank = BK_USR;  // user, system and unlisted codes
    endcase
    priv = (bank != BK_USR);
  end

endmodule

// File: rtl/brf_index_map.sv
module brf_index_map
  import bankreg_pkg::*;
(
  input  bank_e             bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);

  int iv;
  int slot;

  always_comb begin
    iv   = int'(idx);
    slot = iv;
    if (bank == BK_FIQ) begin
      if (iv >= FIQ_LO && iv <= FIQ_HI) slot = group_base(bank) + iv - FIQ_LO;
    end else if (bank != BK_USR) begin
      if (iv >= PAIR_LO && iv < PAIR_LO + PAIR_CNT)
        slot = group_base(bank) + iv - PAIR_LO;
    end
    phys = PHYS_W'(slot);
  end

  // R5: low indices and index 15 always fall on their shared word
  always_comb begin
    if (iv < FIQ_LO || iv == NUM_LOG - 1)
      p_unbanked_r5: assert (int'(phys) == iv);
  end

endmodule

// File: rtl/brf_store.sv
module brf_store
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PHYS_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sv_en,
  input  logic [PHYS_W-1:0] sv_slot,
  input  logic [DATA_W-1:0] sv_data,
  input  logic              st_en,
  input  logic [DATA_W-1:0] st_data,
  input  logic [PHYS_W-1:0] ra_slot,
  input  logic [PHYS_W-1:0] rb_slot,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  output logic [DATA_W-1:0] sv_rdata,
  output logic [DATA_W-1:0] st_rdata
);

  logic [DATA_W-1:0] mem    [DEPTH];
  logic [DATA_W-1:0] d_vec  [DEPTH];
  logic [DEPTH-1:0]  we_vec;

  // next-state: which words load and from which port
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      we_vec[e] = 1'b0;
      d_vec[e]  = wr_data;
      if (wr_en && wr_slot == PHYS_W'(e)) begin
        we_vec[e] = 1'b1;
        d_vec[e]  = wr_data;
      end else if (sv_en && sv_slot == PHYS_W'(e)) begin
        we_vec[e] = 1'b1;
        d_vec[e]  = sv_data;
      end else if (st_en && e == SLOT_STAT) begin
        we_vec[e] = 1'b1;
        d_vec[e]  = st_data;
      end
    end
  end

  // storage with per-word clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (we_vec[e]) mem[e] <= d_vec[e];
      end
    end
  end

  assign ra_data  = mem[ra_slot];
  assign rb_data  = mem[rb_slot];
  assign sv_rdata = mem[sv_slot];
  assign st_rdata = mem[SLOT_STAT];

  // R6: a general write never targets the saved-status word being written
  p_port_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sv_en) |-> (wr_slot != sv_slot));

  // R5: general writes stay inside the array and off the status word
  p_slot_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_slot) < DEPTH && int'(wr_slot) != SLOT_STAT));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stat_wr_en_i,
  input  logic [DATA_W-1:0] stat_wr_data_i,
  output logic [DATA_W-1:0] stat_rd_o,
  input  logic              save_wr_en_i,
  input  logic [DATA_W-1:0] save_wr_data_i,
  output logic [DATA_W-1:0] save_rd_o
);

  localparam int NPORT = 3;  // read A, read B, write

  bank_e             bank;
  logic              priv;
  logic [IDX_W-1:0]  map_idx  [NPORT];
  logic [PHYS_W-1:0] map_phys [NPORT];
  logic [PHYS_W-1:0] save_slot;
  logic [DATA_W-1:0] save_raw;

  brf_mode_decode u_dec (
    .mode (mode_i),
    .bank (bank),
    .priv (priv)
  );

  assign map_idx[0] = rd_a_idx_i;
  assign map_idx[1] = rd_b_idx_i;
  assign map_idx[2] = wr_idx_i;

  for (genvar k = 0; k < NPORT; k++) begin : g_map
    brf_index_map u_map (
      .bank (bank),
      .idx  (map_idx[k]),
      .phys (map_phys[k])
    );
  end

  assign save_slot = PHYS_W'(group_base(bank) + group_size(bank));

  brf_store #(.DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_slot  (map_phys[2]),
    .wr_data  (wr_data_i),
    .sv_en    (save_wr_en_i && priv),
    .sv_slot  (save_slot),
    .sv_data  (save_wr_data_i),
    .st_en    (stat_wr_en_i),
    .st_data  (stat_wr_data_i),
    .ra_slot  (map_phys[0]),
    .rb_slot  (map_phys[1]),
    .ra_data  (rd_a_data_o),
    .rb_data  (rd_b_data_o),
    .sv_rdata (save_raw),
    .st_rdata (stat_rd_o)
  );

  assign save_rd_o = priv ? save_raw : '0;

  // R7: no saved status is visible in user, system or unlisted modes
  p_save_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_USR || mode_i == MD_SYS) |-> (save_rd_o == '0));

  // R9: the status word shows the written value one cycle later
  p_stat_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_en_i |=> (stat_rd_o == $past(stat_wr_data_i)));

  // R10: a write is seen on port A in the next cycle at the same index and mode
  p_wr_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (!(rd_a_idx_i == $past(wr_idx_i) && mode_i == $past(mode_i))
                 || rd_a_data_o == $past(wr_data_i)));

  // R6: a saved-status write in an exception mode is read back next cycle
  p_save_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (save_wr_en_i && mode_i == MD_SVC) |=>
      (mode_i != MD_SVC || save_rd_o == $past(save_wr_data_i)));

endmodule

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;

  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic [4:0]    mode;
  logic [3:0]    ra, rb, wi;
  logic [DW-1:0] ra_d, rb_d, wd, sd, cd, st_o, sv_o;
  logic          we, cw, sw;

  banked_regfile #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .rd_a_idx_i(ra), .rd_a_data_o(ra_d),
    .rd_b_idx_i(rb), .rd_b_data_o(rb_d),
    .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd),
    .stat_wr_en_i(cw), .stat_wr_data_i(cd), .stat_rd_o(st_o),
    .save_wr_en_i(sw), .save_wr_data_i(sd), .save_rd_o(sv_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- independent model, organised by bank ----------------
  logic [DW-1:0] m_usr [16];
  logic [DW-1:0] m_fiq [7];
  logic [DW-1:0] m_pair [4][2];  // irq, svc, abt, und
  logic [DW-1:0] m_sav [5];      // fiq, irq, svc, abt, und
  logic [DW-1:0] m_st;

  function automatic int kind(logic [4:0] md);
    case (md)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [DW-1:0] m_rd(logic [4:0] md, int i);
    int k = kind(md);
    if (k == 1 && i >= 8 && i <= 14) return m_fiq[i-8];
    if (k >= 2 && (i == 13 || i == 14)) return m_pair[k-2][i-13];
    return m_usr[i];
  endfunction

  task automatic m_wr(logic [4:0] md, int i, logic [DW-1:0] v);
    int k = kind(md);
    if (k == 1 && i >= 8 && i <= 14) m_fiq[i-8] = v;
    else if (k >= 2 && (i == 13 || i == 14)) m_pair[k-2][i-13] = v;
    else m_usr[i] = v;
  endtask

  function automatic logic [DW-1:0] m_sv(logic [4:0] md);
    int k = kind(md);
    if (k == 0) return '0;
    return m_sav[k-1];
  endfunction

  // ---------------- scoreboard ----------------
  typedef struct {
    string         tag;
    int            port;
    logic [DW-1:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic push(string tag, int port, logic [DW-1:0] exp);
    item_t it;
    it.tag = tag; it.port = port; it.exp = exp;
    q.push_back(it);
  endtask

  // driver: one cycle of stimulus, expectations from pre-edge model
  task automatic cyc(input logic [4:0] md, input logic w_en, input int w_i,
                     input logic [DW-1:0] w_d, input int a, input int b,
                     input logic s_en, input logic [DW-1:0] s_d,
                     input logic c_en, input logic [DW-1:0] c_d,
                     input string tag);
    @(negedge clk);
    mode = md; we = w_en; wi = 4'(w_i); wd = w_d;
    ra = 4'(a); rb = 4'(b); sw = s_en; sd = s_d; cw = c_en; cd = c_d;
    push(tag, 0, m_rd(md, a));
    push(tag, 1, m_rd(md, b));
    push(tag, 2, m_st);
    push(tag, 3, m_sv(md));
    if (w_en) m_wr(md, w_i, w_d);
    if (s_en && kind(md) != 0) m_sav[kind(md)-1] = s_d;
    if (c_en) m_st = c_d;
  endtask

  task automatic rd(input logic [4:0] md, input int a, input int b, input string tag);
    cyc(md, 0, 0, '0, a, b, 0, '0, 0, '0, tag);
  endtask

  task automatic wr(input logic [4:0] md, input int i, input logic [DW-1:0] v,
                    input string tag);
    cyc(md, 1, i, v, i, 0, 0, '0, 0, '0, tag);
  endtask

  // monitor: pops expectations mid low phase and compares
  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic [DW-1:0] act;
      it = q.pop_front();
      case (it.port)
        0: act = ra_d;
        1: act = rb_d;
        2: act = st_o;
        default: act = sv_o;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s port %0d mode %h actual %h expected %h",
                 it.tag, it.port, mode, act, it.exp);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [31:0] lfsr;
  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  localparam logic [4:0] MODES [9] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17,
                                        5'h1B, 5'h1F, 5'h00, 5'h15};
  localparam logic [4:0] EXC [4] = '{5'h12, 5'h13, 5'h17, 5'h1B};

  initial begin
    for (int i = 0; i < 16; i++) m_usr[i] = '0;
    for (int i = 0; i < 7; i++) m_fiq[i] = '0;
    for (int k = 0; k < 4; k++) begin m_pair[k][0] = '0; m_pair[k][1] = '0; end
    for (int k = 0; k < 5; k++) m_sav[k] = '0;
    m_st = '0;
    rst_n = 1'b0; mode = 5'h10; ra = '0; rb = '0; wi = '0; wd = '0;
    we = 1'b0; sw = 1'b0; sd = '0; cw = 1'b0; cd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything zero after reset
    rd(5'h10, 0, 15, "R1");
    rd(5'h11, 8, 14, "R1");
    rd(5'h13, 13, 14, "R1");
    rd(5'h1B, 13, 7, "R1");

    // R2: user fill, system reads the same set
    for (int i = 0; i < 16; i++) wr(5'h10, i, 32'h1000_0000 + i, "R2");
    for (int i = 0; i < 16; i++) rd(5'h1F, i, 15 - i, "R2");

    // R3: fast-interrupt private copies of 8..14
    for (int i = 8; i <= 14; i++) wr(5'h11, i, 32'hF1F0_0000 + i, "R3");
    for (int i = 8; i <= 14; i++) rd(5'h10, i, i, "R3");
    for (int i = 8; i <= 14; i++) rd(5'h11, i, 22 - i, "R3");
    wr(5'h10, 10, 32'h0BAD_0010, "R3");
    rd(5'h11, 10, 9, "R3");

    // R5: unbanked indices shared across modes
    for (int i = 0; i < 8; i++) rd(5'h11, i, 15, "R5");
    wr(5'h11, 3, 32'hAAAA_0003, "R5");
    wr(5'h13, 15, 32'hAAAA_000F, "R5");
    rd(5'h10, 3, 15, "R5");
    rd(5'h1B, 3, 15, "R5");

    // R4: private pairs for the four other exception modes
    for (int k = 0; k < 4; k++) begin
      wr(EXC[k], 13, 32'hE000_0D00 + k, "R4");
      wr(EXC[k], 14, 32'hE000_0E00 + k, "R4");
    end
    for (int k = 0; k < 4; k++) rd(EXC[k], 13, 14, "R4");
    rd(5'h10, 13, 14, "R4");
    rd(5'h11, 13, 14, "R4");
    rd(5'h12, 12, 8, "R4");

    // R6: saved status per exception mode
    cyc(5'h11, 0, 0, '0, 0, 0, 1, 32'h5A5A_0001, 0, '0, "R6");
    for (int k = 0; k < 4; k++)
      cyc(EXC[k], 0, 0, '0, 0, 0, 1, 32'h5A5A_0010 + k, 0, '0, "R6");
    rd(5'h11, 0, 0, "R6");
    for (int k = 0; k < 4; k++) rd(EXC[k], 13, 0, "R6");

    // R7: user/system saved status reads zero, writes dropped
    cyc(5'h10, 0, 0, '0, 0, 0, 1, 32'hDEAD_0001, 0, '0, "R7");
    cyc(5'h1F, 0, 0, '0, 0, 0, 1, 32'hDEAD_0002, 0, '0, "R7");
    rd(5'h10, 1, 2, "R7");
    rd(5'h1F, 1, 2, "R7");
    rd(5'h11, 1, 2, "R7");
    for (int k = 0; k < 4; k++) rd(EXC[k], 1, 2, "R7");

    // R8: unlisted codes behave as user mode
    rd(5'h00, 13, 9, "R8");
    rd(5'h15, 14, 8, "R8");
    wr(5'h15, 13, 32'h0808_0013, "R8");
    cyc(5'h1E, 0, 0, '0, 0, 0, 1, 32'hDEAD_0003, 0, '0, "R8");
    rd(5'h10, 13, 14, "R8");
    rd(5'h13, 13, 14, "R8");
    rd(5'h00, 0, 0, "R8");

    // R9: one status word for every mode
    cyc(5'h11, 0, 0, '0, 0, 0, 0, '0, 1, 32'hC0DE_0001, "R9");
    rd(5'h10, 0, 0, "R9");
    rd(5'h1B, 0, 0, "R9");
    cyc(5'h1F, 0, 0, '0, 0, 0, 0, '0, 1, 32'hC0DE_0002, "R9");
    rd(5'h12, 0, 0, "R9");

    // R10: same-cycle read sees old value, next cycle sees new
    cyc(5'h10, 1, 5, 32'h7777_0005, 5, 5, 0, '0, 0, '0, "R10");
    rd(5'h10, 5, 5, "R10");
    cyc(5'h13, 1, 14, 32'h7777_000E, 14, 14, 1, 32'h7777_5555, 1, 32'h7777_C0C0, "R10");
    rd(5'h13, 14, 14, "R10");

    // R11: random mixture on all ports
    lfsr = 32'h1234_5679;
    for (int n = 0; n < 400; n++) begin
      logic [4:0] md;
      lfsr = nxt(lfsr);
      md = MODES[int'(lfsr[3:0]) % 9];
      cyc(md, lfsr[4], int'(lfsr[8:5]), nxt(lfsr), int'(lfsr[12:9]),
          int'(lfsr[16:13]), lfsr[17] & lfsr[18], {lfsr[15:0], lfsr[31:16]},
          lfsr[19] & lfsr[20], ~lfsr, "R11");
    end

    rd(5'h10, 0, 1, "R11");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule